// File: doc/BRIEF.md
# Command-pointer register access front end

This block sits between a byte-level two-wire serial slave and a bank of 25 byte-wide registers organised as five groups of five: input levels, output levels, polarity inversion, pin direction and interrupt mask. After the receiver has matched the slave address, the first byte the master writes becomes the command. Its low six bits pick a register and its top bit enables auto-increment. Each later data byte, written or read, is turned into a single-cycle strobe for the register file at the selected index.

With auto-increment on, the slot field (the three low pointer bits) steps after every data byte. It wraps from slot 4 back to slot 0 without leaving the group, so the reserved slots 5 to 7 are never reached. Writes to the read-only input group and to reserved or undefined locations are refused with no acknowledge. Reads from those reserved or undefined locations return zero. The pointer is kept across STOP and repeated START, so a master can write a command and then read back from that register in a new transfer.

Top module: `ioexp_reg_access`

## Requirements
- R1: After reset the command holds pointer 0x00 with auto-increment on: reg_idx_o is 0x00, no strobe or acknowledge is active, and two reads in a fresh transfer hit indices 0x00 and then 0x01.
- R2: A written byte with first_byte_i=1 loads the command: bits 5:0 become the pointer (visible on reg_idx_o the next cycle) and bit 7 becomes the auto-increment flag. The byte is acknowledged and produces no strobe.
- R3: With auto-increment on, every data byte, read or written, advances pointer bits 2:0 after use. Slot 4 and slots 5 to 7 advance to slot 0, and pointer bits 5:3 (the group) never change.
- R4: With auto-increment off, consecutive data bytes all use the same index.
- R5: A written data byte to group 1 to 4 (bits 5:3) at slot 0 to 4 raises wr_stb_o for that cycle, with wr_data_o equal to the byte and ack_o=1.
- R6: A written data byte to group 0 (input levels, read-only) gives no wr_stb_o and ack_o=0.
- R7: A location with slot 5 to 7 or group 5 to 7 is stored as the pointer. Writes to it give no strobe and ack_o=0. Reads give no rd_stb_o, and rd_data_o is 0x00.
- R8: A read byte (rd_dir_i=1) at a valid location raises rd_stb_o and passes rd_data_i to rd_data_o, with ack_o=0.
- R9: The pointer and the auto-increment flag keep their values across STOP and START events, including a repeated START.
- R10: Bytes that arrive after a STOP and before the next START are ignored: no strobe, no acknowledge and no pointer change.
- R11: With auto-increment on, a sixth consecutive write in a group lands on the same index as the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_i | input | 1 | STOP seen (one-cycle pulse) |
| byte_valid_i | input | 1 | A byte slot completes this cycle |
| first_byte_i | input | 1 | Written byte is the first after the address (command) |
| rd_dir_i | input | 1 | 1 = read transfer byte, 0 = written byte |
| byte_i | input | 8 | Received byte |
| rd_data_i | input | 8 | Data from the register file at reg_idx_o |
| reg_idx_o | output | 6 | Current register pointer |
| wr_stb_o | output | 1 | Register write strobe |
| wr_data_o | output | 8 | Write data |
| rd_stb_o | output | 1 | Register read strobe |
| rd_data_o | output | 8 | Byte handed to the transmitter |
| ack_o | output | 1 | Acknowledge decision for the written byte |

## Verification
The hardest case to reach is the walk from a reserved slot. The pointer has to be parked at slot 5 by a command byte, and then a refused write has to move it. The next access should land on slot 0 of the same group, not on slot 6 and not in the next group. The stimulus table loads such a command, writes once (which must be refused) and then reads twice, checking the index each time. A second sequence puts a stop-to-start gap and a repeated START between the command and the reads, to show that the pointer is retained and that stray bytes between transfers are ignored.

// File: rtl/ioexp_acc_pkg.sv
package ioexp_acc_pkg;
  localparam int unsigned DATA_W_D   = 8;
  localparam int unsigned GRP_W_D    = 3;
  localparam int unsigned SLOT_W_D   = 3;
  localparam int unsigned NUM_GRP_D  = 5;
  localparam int unsigned GRP_SIZE_D = 5;
  localparam int unsigned RO_GRP_D   = 0;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_CMD  = 2'd1,
    EV_WDAT = 2'd2,
    EV_RDAT = 2'd3
  } byte_ev_e;
endpackage

// File: rtl/acc_xfer_track.sv
module acc_xfer_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic active_o
);
  logic active_q;

  // repeated START wins over a coincident STOP
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (start_i) active_q <= 1'b1;
    else if (stop_i)  active_q <= 1'b0;
  end

  assign active_o = active_q;
endmodule

// File: rtl/acc_cmd_reg.sv
module acc_cmd_reg #(
  parameter int unsigned GRP_W    = 3,
  parameter int unsigned SLOT_W   = 3,
  parameter int unsigned GRP_SIZE = 5,
  localparam int unsigned PTR_W   = GRP_W + SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             ai_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             ai_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic              ai_q;
  logic [SLOT_W-1:0] slot, slot_nxt;

  assign slot = ptr_q[SLOT_W-1:0];

  // last valid slot and reserved slots all fold back to slot 0
  always_comb begin
    if (slot >= SLOT_W'(GRP_SIZE - 1)) slot_nxt = '0;
    else                               slot_nxt = slot + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ai_q  <= 1'b1;
    end else if (load_i) begin
      ptr_q <= ptr_i;
      ai_q  <= ai_i;
    end else if (step_i && ai_q) begin
      ptr_q[SLOT_W-1:0] <= slot_nxt;
    end
  end

  assign ptr_o = ptr_q;
  assign ai_o  = ai_q;
endmodule

// File: rtl/acc_loc_decode.sv
module acc_loc_decode #(
  parameter int unsigned GRP_W    = 3,
  parameter int unsigned SLOT_W   = 3,
  parameter int unsigned NUM_GRP  = 5,
  parameter int unsigned GRP_SIZE = 5,
  parameter int unsigned RO_GRP   = 0,
  localparam int unsigned PTR_W   = GRP_W + SLOT_W
) (
  input  logic [PTR_W-1:0] ptr_i,
  output logic             valid_o,
  output logic             writable_o
);
  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;

  assign grp  = ptr_i[PTR_W-1:SLOT_W];
  assign slot = ptr_i[SLOT_W-1:0];

  assign valid_o    = (grp < GRP_W'(NUM_GRP)) && (slot < SLOT_W'(GRP_SIZE));
  assign writable_o = valid_o && (grp != GRP_W'(RO_GRP));
endmodule

// File: rtl/ioexp_reg_access.sv
module ioexp_reg_access
  import ioexp_acc_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_D,
  parameter int unsigned GRP_W    = GRP_W_D,
  parameter int unsigned SLOT_W   = SLOT_W_D,
  parameter int unsigned NUM_GRP  = NUM_GRP_D,
  parameter int unsigned GRP_SIZE = GRP_SIZE_D,
  parameter int unsigned RO_GRP   = RO_GRP_D,
  localparam int unsigned PTR_W   = GRP_W + SLOT_W,
  localparam int unsigned AI_POS  = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic              first_byte_i,
  input  logic              rd_dir_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [PTR_W-1:0]  reg_idx_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_stb_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ack_o
);
  logic             active;
  logic [PTR_W-1:0] ptr;
  logic             ai;
  logic             loc_valid, loc_wr;
  byte_ev_e         ev;

  acc_xfer_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .active_o (active)
  );

  always_comb begin
    ev = EV_NONE;
    if (byte_valid_i && active) begin
      if (rd_dir_i)          ev = EV_RDAT;
      else if (first_byte_i) ev = EV_CMD;
      else                   ev = EV_WDAT;
    end
  end

  acc_cmd_reg #(
    .GRP_W    (GRP_W),
    .SLOT_W   (SLOT_W),
    .GRP_SIZE (GRP_SIZE)
  ) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ev == EV_CMD),
    .ptr_i  (byte_i[PTR_W-1:0]),
    .ai_i   (byte_i[AI_POS]),
    .step_i ((ev == EV_WDAT) || (ev == EV_RDAT)),
    .ptr_o  (ptr),
    .ai_o   (ai)
  );

  acc_loc_decode #(
    .GRP_W    (GRP_W),
    .SLOT_W   (SLOT_W),
    .NUM_GRP  (NUM_GRP),
    .GRP_SIZE (GRP_SIZE),
    .RO_GRP   (RO_GRP)
  ) u_dec (
    .ptr_i      (ptr),
    .valid_o    (loc_valid),
    .writable_o (loc_wr)
  );

  assign reg_idx_o = ptr;
  assign wr_data_o = byte_i;
  assign wr_stb_o  = (ev == EV_WDAT) && loc_wr;
  assign rd_stb_o  = (ev == EV_RDAT) && loc_valid;
  assign ack_o     = (ev == EV_CMD) || wr_stb_o;
  assign rd_data_o = loc_valid ? rd_data_i : '0;

  logic unused_ai;
  assign unused_ai = ai;
endmodule

// File: rtl/ioexp_reg_access_chk.sv
module ioexp_reg_access_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned GRP_W    = 3,
  parameter int unsigned SLOT_W   = 3,
  parameter int unsigned GRP_SIZE = 5,
  localparam int unsigned PTR_W   = GRP_W + SLOT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic              first_byte_i,
  input logic              rd_dir_i,
  input logic [PTR_W-1:0]  reg_idx_o,
  input logic              wr_stb_o,
  input logic              rd_stb_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ack_o
);
  // R3
  grp_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o || rd_stb_o) |=> reg_idx_o[PTR_W-1:SLOT_W] == $past(reg_idx_o[PTR_W-1:SLOT_W]));

  // R10
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> $stable(reg_idx_o));

  // R5
  wr_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> ack_o && !rd_dir_i && !first_byte_i);

  // R6
  ro_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !rd_dir_i && !first_byte_i && reg_idx_o[PTR_W-1:SLOT_W] == '0)
      |-> !wr_stb_o && !ack_o);

  // R7
  rsv_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && rd_dir_i && reg_idx_o[SLOT_W-1:0] >= SLOT_W'(GRP_SIZE))
      |-> !rd_stb_o && rd_data_o == '0);

  // R8
  rd_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |-> !wr_stb_o && !ack_o);
endmodule

bind ioexp_reg_access ioexp_reg_access_chk #(
  .DATA_W   (DATA_W),
  .GRP_W    (GRP_W),
  .SLOT_W   (SLOT_W),
  .GRP_SIZE (GRP_SIZE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_i (byte_valid_i),
  .first_byte_i (first_byte_i),
  .rd_dir_i     (rd_dir_i),
  .reg_idx_o    (reg_idx_o),
  .wr_stb_o     (wr_stb_o),
  .rd_stb_o     (rd_stb_o),
  .rd_data_o    (rd_data_o),
  .ack_o        (ack_o)
);

// File: tb/tb_ioexp_reg_access.sv
module tb_ioexp_reg_access;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0;
  logic       byte_valid_i = 1'b0, first_byte_i = 1'b0, rd_dir_i = 1'b0;
  logic [7:0] byte_i = '0, rd_data_i = '0;
  logic [5:0] reg_idx_o;
  logic       wr_stb_o, rd_stb_o, ack_o;
  logic [7:0] wr_data_o, rd_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ioexp_reg_access dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .first_byte_i(first_byte_i), .rd_dir_i(rd_dir_i),
    .byte_i(byte_i), .rd_data_i(rd_data_i), .reg_idx_o(reg_idx_o),
    .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o), .rd_stb_o(rd_stb_o),
    .rd_data_o(rd_data_o), .ack_o(ack_o)
  );

  typedef struct packed {
    logic       rd;
    logic       first;
    logic [7:0] dat;
    logic [7:0] rdin;
    logic [5:0] idx;
    logic       wr;
    logic       rs;
    logic       ack;
    logic [7:0] rdo;
  } vec_t;

  // pointer idx is the value in use during the byte
  localparam vec_t VEC [0:21] = '{
    '{1'b0, 1'b1, 8'h88, 8'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'h00}, // R2 cmd 0x08 AI
    '{1'b0, 1'b0, 8'hAA, 8'h00, 6'h08, 1'b1, 1'b0, 1'b1, 8'h00}, // R5
    '{1'b0, 1'b0, 8'hBB, 8'h00, 6'h09, 1'b1, 1'b0, 1'b1, 8'h00}, // R3
    '{1'b0, 1'b0, 8'hCC, 8'h00, 6'h0A, 1'b1, 1'b0, 1'b1, 8'h00},
    '{1'b0, 1'b0, 8'hDD, 8'h00, 6'h0B, 1'b1, 1'b0, 1'b1, 8'h00},
    '{1'b0, 1'b0, 8'hEE, 8'h00, 6'h0C, 1'b1, 1'b0, 1'b1, 8'h00},
    '{1'b0, 1'b0, 8'hFF, 8'h00, 6'h08, 1'b1, 1'b0, 1'b1, 8'h00}, // R11 wrap
    '{1'b0, 1'b1, 8'h24, 8'h00, 6'h09, 1'b0, 1'b0, 1'b1, 8'h00}, // R2 AI off
    '{1'b0, 1'b0, 8'h11, 8'h00, 6'h24, 1'b1, 1'b0, 1'b1, 8'h00}, // R4
    '{1'b0, 1'b0, 8'h22, 8'h00, 6'h24, 1'b1, 1'b0, 1'b1, 8'h00}, // R4
    '{1'b0, 1'b1, 8'h82, 8'h00, 6'h24, 1'b0, 1'b0, 1'b1, 8'h00},
    '{1'b0, 1'b0, 8'h33, 8'h00, 6'h02, 1'b0, 1'b0, 1'b0, 8'h00}, // R6
    '{1'b0, 1'b0, 8'h44, 8'h00, 6'h03, 1'b0, 1'b0, 1'b0, 8'h00}, // R6
    '{1'b0, 1'b1, 8'h8D, 8'h00, 6'h04, 1'b0, 1'b0, 1'b1, 8'h00}, // R7 slot 5
    '{1'b0, 1'b0, 8'h55, 8'h77, 6'h0D, 1'b0, 1'b0, 1'b0, 8'h00}, // R7
    '{1'b1, 1'b0, 8'h00, 8'h77, 6'h08, 1'b0, 1'b1, 1'b0, 8'h77}, // R3 R8
    '{1'b1, 1'b0, 8'h00, 8'h66, 6'h09, 1'b0, 1'b1, 1'b0, 8'h66}, // R8
    '{1'b0, 1'b1, 8'hA8, 8'h00, 6'h0A, 1'b0, 1'b0, 1'b1, 8'h00}, // group 5
    '{1'b1, 1'b0, 8'h00, 8'h99, 6'h28, 1'b0, 1'b0, 1'b0, 8'h00}, // R7
    '{1'b0, 1'b1, 8'h1C, 8'h00, 6'h29, 1'b0, 1'b0, 1'b1, 8'h00},
    '{1'b1, 1'b0, 8'h00, 8'h42, 6'h1C, 1'b0, 1'b1, 1'b0, 8'h42}, // R4 read
    '{1'b1, 1'b0, 8'h00, 8'h43, 6'h1C, 1'b0, 1'b1, 1'b0, 8'h43}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic put_byte(input logic rd, input logic first, input logic [7:0] d,
                          input logic [7:0] rin);
    @(negedge clk);
    byte_valid_i = 1'b1; rd_dir_i = rd; first_byte_i = first; byte_i = d; rd_data_i = rin;
    #1;
  endtask

  task automatic end_byte();
    @(negedge clk);
    byte_valid_i = 1'b0; first_byte_i = 1'b0; rd_dir_i = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #1;
    // R1 reset state
    check("R1 idx in reset", int'(reg_idx_o), 0);
    check("R1 strobes in reset", int'({wr_stb_o, rd_stb_o, ack_o}), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    pulse_start();

    foreach (VEC[i]) begin
      put_byte(VEC[i].rd, VEC[i].first, VEC[i].dat, VEC[i].rdin);
      check($sformatf("R2/R3/R4/R11 idx v%0d", i), int'(reg_idx_o), int'(VEC[i].idx));
      check($sformatf("R5/R6/R7 wr_stb v%0d", i), int'(wr_stb_o), int'(VEC[i].wr));
      check($sformatf("R7/R8 rd_stb v%0d", i), int'(rd_stb_o), int'(VEC[i].rs));
      check($sformatf("R2/R5/R6 ack v%0d", i), int'(ack_o), int'(VEC[i].ack));
      check($sformatf("R7/R8 rd_data v%0d", i), int'(rd_data_o), int'(VEC[i].rdo));
      if (VEC[i].wr) check($sformatf("R5 wr_data v%0d", i), int'(wr_data_o), int'(VEC[i].dat));
      end_byte();
    end

    // R10: bytes between STOP and START are dropped
    pulse_stop();
    put_byte(1'b0, 1'b1, 8'h85, 8'h00);
    check("R10 ack while idle", int'(ack_o), 0);
    end_byte();
    put_byte(1'b0, 1'b0, 8'h12, 8'h00);
    check("R10 wr_stb while idle", int'(wr_stb_o), 0);
    end_byte();
    check("R10 idx after idle bytes", int'(reg_idx_o), 'h1C);

    // R9: pointer kept across STOP/START and repeated START
    pulse_start();
    put_byte(1'b1, 1'b0, 8'h00, 8'h5C);
    check("R9 idx after restart", int'(reg_idx_o), 'h1C);
    check("R9 rd_stb after restart", int'(rd_stb_o), 1);
    end_byte();
    put_byte(1'b0, 1'b1, 8'h8A, 8'h00);
    end_byte();
    pulse_start();
    put_byte(1'b1, 1'b0, 8'h00, 8'h3E);
    check("R9 idx after repeated start", int'(reg_idx_o), 'h0A);
    check("R9 rd_data after repeated start", int'(rd_data_o), 'h3E);
    end_byte();
    check("R9 R3 idx advanced", int'(reg_idx_o), 'h0B);

    // R1: asynchronous reset mid-run restores pointer 0 with auto-increment
    @(negedge clk); rst_ni = 1'b0; #1;
    check("R1 idx after reset", int'(reg_idx_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    pulse_start();
    put_byte(1'b1, 1'b0, 8'h00, 8'h01);
    check("R1 first read idx", int'(reg_idx_o), 0);
    end_byte();
    put_byte(1'b1, 1'b0, 8'h00, 8'h02);
    check("R1 second read idx", int'(reg_idx_o), 1);
    end_byte();
    pulse_stop();

    finish_run();
  end
endmodule